// File: doc/BRIEF.md
# Sub-Clock Delayed Pulse Generator

The block turns trigger edges into timed output pulses on a bank of independent channels. Each clock carries eight time samples per channel. The input side delivers these as a parallel word from an input deserializer, and the output side hands a parallel word to an output serializer. Bit 0 of each word is the earliest sample. A channel finds a rising edge in its incoming sample stream and waits a programmed number of sample times. It then drives its output high for a second programmed number of sample times. Both edges of the pulse are placed to a single sample, not to a whole clock.

A channel has two phases in a chain. First a delay one-shot is started by the trigger. When it expires, a width one-shot starts. Each phase is a coarse word counter compared for equality against a target. The sample position within a word is kept beside the counter and becomes a partial-word mask at the first and last word of the pulse. Settings are written through a single-cycle write port that selects a channel and a field.

Top module: `pgen_top`

## Requirements
- R1: While `rst` is high, and on the first output word after it, every output bit is 0. This holds whatever the trigger inputs carry. Reset also clears every delay and width setting to 0 and clears the remembered last input sample to 0.
- R2: A trigger is the first sample in a word that is 1 while the sample before it is 0. For bit 0, the sample before it is bit 7 of the previous word. Bit 0 is the earliest sample. Any later rising edge in the same word is not used.
- R3: With trigger sample T and delay setting D, the first high output sample is T+D. Output word n+1 carries the sample times of input word n, so there is one clock of latency.
- R4: With width setting W, the output is high for exactly W consecutive samples, from sample T+D through sample T+D+W-1.
- R5: A pulse edge that falls inside a word affects only that word's bits from the edge position onward. A pulse that starts and ends in the same word sets only the bits between its two edges.
- R6: A delay of 0 starts the pulse at the trigger sample itself, in the same output word.
- R7: A width of 0 produces no output, and the trigger is not taken.
- R8: A trigger is taken only in a word later than the word holding sample T+D+W, the first low sample after the pulse. Rising edges in earlier words, during the delay or the pulse, are ignored.
- R9: A write with `cfg_we`=1 stores `cfg_data` into channel `cfg_ch`. `cfg_sel`=0 selects the delay and `cfg_sel`=1 selects the width. Other channels are not changed.
- R10: Delay and width each cover their full 16-bit range, 0 to 65535 samples, and the two values add without overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Setting write strobe |
| cfg_ch | input | CH_W | Channel index of the write |
| cfg_sel | input | 1 | 0 = delay, 1 = width |
| cfg_data | input | SET_W | Setting value in sample times |
| trig_words | input | NUM_CH*8 | Input sample words, channel c at bits [8c+7:8c] |
| pulse_words | output | NUM_CH*8 | Output sample words, same layout, bit 0 earliest |

## Verification
The bench builds the block with two channels and the default 16-bit settings. Two channels are enough to show that a write to one channel leaves the other alone, and to run differing settings side by side. The full 16-bit settings let a 65535-sample delay and a 65535-sample width run to their end in about eight thousand words. The coarse counters then reach their top values, and the carry from the sub-word position into the coarse count is exercised.

// File: rtl/pgen_pkg.sv
package pgen_pkg;

  localparam int unsigned LANES  = 8;
  localparam int unsigned LANE_W = $clog2(LANES);

  typedef logic [LANES-1:0] lane_word_t;

  typedef struct packed {
    logic              hit;
    logic [LANE_W-1:0] pos;
  } edge_t;

  // first 0->1 transition in a word, the bit before lane 0 being prev
  function automatic edge_t first_rise(lane_word_t w, logic prev);
    edge_t r;
    logic  last;
    r.hit = 1'b0;
    r.pos = '0;
    last  = prev;
    for (int i = 0; i < LANES; i++) begin
      if (!r.hit && w[i] && !last) begin
        r.hit = 1'b1;
        r.pos = LANE_W'(i);
      end
      last = w[i];
    end
    return r;
  endfunction

  // lanes at or after position lo
  function automatic lane_word_t lanes_from(logic [LANE_W-1:0] lo);
    lane_word_t m;
    for (int i = 0; i < LANES; i++) m[i] = (i >= int'(lo));
    return m;
  endfunction

  // lanes strictly before position hi
  function automatic lane_word_t lanes_before(logic [LANE_W-1:0] hi);
    lane_word_t m;
    for (int i = 0; i < LANES; i++) m[i] = (i < int'(hi));
    return m;
  endfunction

endpackage

// File: rtl/pgen_edge.sv
module pgen_edge
  import pgen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  lane_word_t smp,
  output edge_t      ev
);

  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= smp[LANES-1];
  end

  assign ev = first_rise(smp, prev_q);

  // R2: a reported trigger lane is itself high
  a_r2_hit_is_high: assert property (@(posedge clk) disable iff (rst)
    ev.hit |-> smp[ev.pos]);

endmodule

// File: rtl/pgen_oneshot.sv
module pgen_oneshot #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] tgt,
  output logic             active,
  output logic             fire,
  output logic             run_o
);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] tgt_q;

  always_comb begin
    fire   = start ? (tgt == '0) : (run_q && (cnt_q == tgt_q));
    active = start || run_q;
  end

  assign run_o = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
      tgt_q <= '0;
    end else if (start && (tgt != '0)) begin
      run_q <= 1'b1;
      cnt_q <= CNT_W'(1);
      tgt_q <= tgt;
    end else if (run_q) begin
      if (cnt_q == tgt_q) run_q <= 1'b0;
      else                cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  // R3: while counting, the word count never passes its target
  a_r3_cnt_bounded: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (cnt_q != '0) && (cnt_q <= tgt_q));

  // R8: a running one-shot is never restarted
  a_r8_no_restart: assert property (@(posedge clk) disable iff (rst)
    start |-> !run_q);

endmodule

// File: rtl/pgen_channel.sv
module pgen_channel
  import pgen_pkg::*;
#(
  parameter int SET_W = 16,
  parameter int CNT_W = SET_W - LANE_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we_dly,
  input  logic             we_wid,
  input  logic [SET_W-1:0] wdata,
  input  lane_word_t       smp,
  output lane_word_t       pulse_o
);

  logic [SET_W-1:0] dly_q, wid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dly_q <= '0;
      wid_q <= '0;
    end else begin
      if (we_dly) dly_q <= wdata;
      if (we_wid) wid_q <= wdata;
    end
  end

  edge_t ev;
  pgen_edge u_edge (.clk(clk), .rst(rst), .smp(smp), .ev(ev));

  logic d_act, d_fire, d_run;
  logic w_act, w_fire, w_run;
  logic busy, accept, w_start;

  assign busy   = d_run || w_run;
  assign accept = ev.hit && !busy && (wid_q != '0);

  // delay phase: trigger lane plus delay, split into words and a lane
  logic [SET_W:0]     rise_sum;
  logic [LANE_W-1:0]  rf_q, rise_f;
  logic [CNT_W-1:0]   d_tgt;

  assign rise_sum = {1'b0, dly_q} + (SET_W+1)'(ev.pos);
  assign d_tgt    = rise_sum[SET_W:LANE_W];
  assign rise_f   = accept ? rise_sum[LANE_W-1:0] : rf_q;

  pgen_oneshot #(.CNT_W(CNT_W)) u_dly (
    .clk(clk), .rst(rst), .start(accept), .tgt(d_tgt),
    .active(d_act), .fire(d_fire), .run_o(d_run));

  // width phase: starts in the word the delay expires
  logic [SET_W:0]     fall_sum;
  logic [LANE_W-1:0]  ff_q, fall_f;
  logic [CNT_W-1:0]   w_tgt;

  assign w_start  = d_fire;
  assign fall_sum = {1'b0, wid_q} + (SET_W+1)'(rise_f);
  assign w_tgt    = fall_sum[SET_W:LANE_W];
  assign fall_f   = w_start ? fall_sum[LANE_W-1:0] : ff_q;

  pgen_oneshot #(.CNT_W(CNT_W)) u_wid (
    .clk(clk), .rst(rst), .start(w_start), .tgt(w_tgt),
    .active(w_act), .fire(w_fire), .run_o(w_run));

  always_ff @(posedge clk) begin
    if (rst) begin
      rf_q <= '0;
      ff_q <= '0;
    end else begin
      if (accept)  rf_q <= rise_sum[LANE_W-1:0];
      if (w_start) ff_q <= fall_sum[LANE_W-1:0];
    end
  end

  lane_word_t mask;
  always_comb begin
    mask = '0;
    if (w_act) begin
      mask = w_start ? lanes_from(rise_f) : '1;
      if (w_fire) mask = mask & lanes_before(fall_f);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pulse_o <= '0;
    else     pulse_o <= mask;
  end

  // R1: reset forces the output word low
  a_r1_reset_low: assert property (@(posedge clk)
    rst |=> (pulse_o == '0));

  // R8: delay and width phases never overlap
  a_r8_phases_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(d_run && w_run));

  // R4: a middle word of the pulse is fully high
  a_r4_full_word: assert property (@(posedge clk) disable iff (rst)
    (w_run && !w_fire) |=> (pulse_o == '1));

  // R7: no width phase means a quiet output word
  a_r7_quiet: assert property (@(posedge clk) disable iff (rst)
    !w_act |=> (pulse_o == '0));

  // R3: the delay phase never runs with the output high in the same word
  a_r3_delay_low: assert property (@(posedge clk) disable iff (rst)
    (d_run && !d_fire) |=> (pulse_o == '0));

endmodule

// File: rtl/pgen_top.sv
module pgen_top
  import pgen_pkg::*;
#(
  parameter int NUM_CH = 32,
  parameter int SET_W  = 16,
  parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [CH_W-1:0]          cfg_ch,
  input  logic                     cfg_sel,
  input  logic [SET_W-1:0]         cfg_data,
  input  logic [NUM_CH*LANES-1:0]  trig_words,
  output logic [NUM_CH*LANES-1:0]  pulse_words
);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic       hit;
    lane_word_t pw;

    assign hit = cfg_we && (cfg_ch == CH_W'(g));

    pgen_channel #(.SET_W(SET_W)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .we_dly  (hit && !cfg_sel),
      .we_wid  (hit && cfg_sel),
      .wdata   (cfg_data),
      .smp     (trig_words[g*LANES +: LANES]),
      .pulse_o (pw)
    );

    assign pulse_words[g*LANES +: LANES] = pw;
  end

endmodule

// File: tb/pgen_top_test.sv
module pgen_top_test;

  localparam int NCH  = 2;
  localparam int SW   = 16;
  localparam int CHW  = 1;
  localparam int MAXW = 8300;
  localparam int MAXS = MAXW * 8;

  logic clk = 1'b0;
  logic rst, cfg_we, cfg_sel;
  logic [CHW-1:0]   cfg_ch;
  logic [SW-1:0]    cfg_data;
  logic [NCH*8-1:0] trig, pulse;

  always #5 clk = ~clk;

  pgen_top #(.NUM_CH(NCH), .SET_W(SW)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
    .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .trig_words(trig), .pulse_words(pulse));

  int checks = 0;
  int fails  = 0;
  int dly [NCH];
  int wid [NCH];
  bit in_s [NCH][MAXS];
  bit ex_s [NCH][MAXS];
  bit ac_s [NCH][MAXS];

  task automatic clear_all();
    for (int c = 0; c < NCH; c++)
      for (int s = 0; s < MAXS; s++) begin
        in_s[c][s] = 1'b0; ex_s[c][s] = 1'b0; ac_s[c][s] = 1'b0;
      end
  endtask

  task automatic level(int ch, int from, int to);
    for (int s = from; s < to; s++) in_s[ch][s] = 1'b1;
  endtask

  task automatic cfg(int ch, bit sel, int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CHW'(ch); cfg_sel = sel; cfg_data = SW'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel) wid[ch] = val; else dly[ch] = val;
  endtask

  // expected samples from the requirements; returns word of first low sample
  function automatic int model(int ch, int nw);
    int lastfw = -1;
    bit prev   = 1'b0;
    for (int k = 0; k < nw; k++) begin
      int p = -1;
      for (int i = 0; i < 8; i++) begin
        bit b = in_s[ch][8*k+i];
        if (p < 0 && b && !prev) p = i;
        prev = b;
      end
      if (p >= 0 && k > lastfw && wid[ch] != 0) begin
        int r = 8*k + p + dly[ch];
        int f = r + wid[ch];
        for (int s = r; s < f; s++) if (s < MAXS) ex_s[ch][s] = 1'b1;
        lastfw = f / 8;
      end
    end
    return lastfw;
  endfunction

  task automatic check_seq(int ch, int nw, string tag);
    int bad = -1;
    logic [7:0] a, e, ba, be;
    ba = '0; be = '0;
    for (int w = 0; w < nw; w++) begin
      for (int i = 0; i < 8; i++) begin
        a[i] = ac_s[ch][8*w+i];
        e[i] = ex_s[ch][8*w+i];
      end
      if (bad < 0 && a != e) begin bad = w; ba = a; be = e; end
    end
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s ch%0d word %0d: actual %b expected %b", tag, ch, bad, ba, be);
    end
  endtask

  task automatic run_and_check(int nw, string tag0, string tag1);
    int need = nw;
    for (int c = 0; c < NCH; c++) begin
      int lf = model(c, nw);
      if (lf + 2 > need) need = lf + 2;
    end
    if (need > MAXW - 1) need = MAXW - 1;
    for (int k = 0; k <= need; k++) begin
      @(negedge clk);
      if (k > 0)
        for (int c = 0; c < NCH; c++)
          for (int i = 0; i < 8; i++) ac_s[c][8*(k-1)+i] = pulse[c*8+i];
      for (int c = 0; c < NCH; c++)
        for (int i = 0; i < 8; i++)
          trig[c*8+i] = (k < nw) ? in_s[c][8*k+i] : 1'b0;
    end
    check_seq(0, need, tag0);
    check_seq(1, need, tag1);
  endtask

  // R1 and R7: reset state, then default zero settings give no pulse
  task automatic t_reset();
    rst = 1'b1; trig = '1;
    repeat (3) @(negedge clk);
    checks++;
    if (pulse !== '0) begin
      fails++; $display("FAIL R1 output in reset: actual %b expected 0", pulse);
    end
    trig = '0;
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < NCH; c++) begin dly[c] = 0; wid[c] = 0; end
    @(negedge clk);
    checks++;
    if (pulse !== '0) begin
      fails++; $display("FAIL R1 output after reset: actual %b expected 0", pulse);
    end
    clear_all();
    level(0, 5, 9); level(1, 12, 20);
    run_and_check(4, "R7 default width zero", "R7 default width zero");
  endtask

  // R3, R4: basic delay and width across several words
  task automatic t_basic();
    cfg(0, 0, 20); cfg(0, 1, 13); cfg(1, 0, 5); cfg(1, 1, 30);
    clear_all();
    level(0, 3, 30); level(1, 9, 11);
    run_and_check(5, "R3 R4 ch0", "R3 R4 ch1");
  endtask

  // R5: edges inside a word and a pulse wholly inside one word
  task automatic t_inword();
    cfg(0, 0, 2); cfg(0, 1, 3); cfg(1, 0, 6); cfg(1, 1, 2);
    clear_all();
    level(0, 17, 18); level(1, 1, 4);
    run_and_check(4, "R5 same word", "R5 word boundary");
  endtask

  // R6: zero delay
  task automatic t_zero_delay();
    cfg(0, 0, 0); cfg(0, 1, 4); cfg(1, 0, 0); cfg(1, 1, 1);
    clear_all();
    level(0, 10, 12); level(1, 0, 3);
    run_and_check(3, "R6 ch0", "R6 ch1 lane0");
  endtask

  // R2: edge across word boundary, held high, and first of two edges
  task automatic t_edges();
    cfg(0, 0, 1); cfg(0, 1, 1); cfg(1, 0, 8); cfg(1, 1, 1);
    clear_all();
    level(0, 4, 13); level(0, 16, 19);
    level(1, 24, 25); level(1, 26, 28);
    run_and_check(4, "R2 boundary", "R2 first edge");
  endtask

  // R8: triggers during delay, during width and in the final word ignored
  task automatic t_busy();
    cfg(0, 0, 10); cfg(0, 1, 10); cfg(1, 0, 4); cfg(1, 1, 4);
    clear_all();
    level(0, 2, 4); level(0, 15, 16); level(0, 20, 21); level(0, 26, 27);
    level(1, 0, 1); level(1, 9, 10); level(1, 17, 18);
    run_and_check(5, "R8 ch0", "R8 final word");
  endtask

  // R10: full range delay and width
  task automatic t_large();
    cfg(0, 0, 65535); cfg(0, 1, 3); cfg(1, 0, 9); cfg(1, 1, 65535);
    clear_all();
    level(0, 7, 8); level(1, 0, 1);
    run_and_check(2, "R10 max delay", "R10 max width");
  endtask

  // R9: writes to one channel leave the other unchanged
  task automatic t_channels();
    cfg(0, 0, 7); cfg(0, 1, 5); cfg(1, 0, 40); cfg(1, 1, 2);
    cfg(1, 1, 9);
    clear_all();
    level(0, 3, 5); level(1, 3, 5);
    run_and_check(3, "R9 ch0 untouched", "R9 ch1 written");
  endtask

  initial begin
    cfg_we = 1'b0; cfg_sel = 1'b0; cfg_ch = '0; cfg_data = '0;
    trig = '0; rst = 1'b1;
    t_reset();
    t_basic();
    t_inword();
    t_zero_delay();
    t_edges();
    t_busy();
    t_large();
    t_channels();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule